// File: doc/BRIEF.md
# Free-Running Timer with Watchdog Match

This block keeps a wide up-counter that advances by one on every qualifying tick of a slow timebase and wraps at the top of its range. Several compare channels sit beside it, each holding a value that software programs. When a tick arrives while the counter holds a channel's value and that channel's interrupt is enabled, a sticky status flag is raised. The flag also drives that channel's interrupt request line until software clears it by writing a one to its position.

The highest-numbered compare channel doubles as a watchdog. Once software arms the watchdog, a match on that channel raises a registered system reset request for a fixed number of clocks. The interrupt enable has no bearing on this. The arming control is write-once-to-set: only a reset disarms it. No reset ever clears the counter, the compare values, the interrupt enables or the status flags, so software must set them up before it relies on them.

The watchdog is a small state machine with three states. WD_IDLE means disarmed, and it is the only state left by reset. WD_ARMED means the watchdog is waiting for a match. WD_FIRING means the reset request is being driven. The transitions are: arm (WD_IDLE to WD_ARMED, on a write of one to the arm bit), trip (WD_ARMED to WD_FIRING, on a watchdog-channel match) and release (WD_FIRING back to WD_ARMED, once the pulse has lasted its full length).

Top module: `frt_wdt_timer`

## Requirements
- R1: On each clock edge with `tick_i` high, the counter increases by one, wrapping from all-ones to zero. With `tick_i` low it holds. A bus write to word 4 loads the written value in place of the increment.
- R2: Reset does not change the counter or the compare values. After reset the watchdog arm bit (word 7, bit 0) reads 0 and `wdt_rst_o` is 0.
- R3: Compare values for channels 0 to 3 are written and read at words 0 to 3, at full width.
- R4: Status bit i (word 5, bit i) is set at the clock edge where `tick_i` is high, the counter equals compare value i, and interrupt enable bit i (word 6, bit i) is set. With the enable bit clear, the bit is not set.
- R5: `irq_o[i]` equals status bit i.
- R6: Writing word 5 clears each status bit whose written bit is one and leaves the others alone. A set and a clear of the same bit at the same edge leave the bit set.
- R7: A match is counted only on a tick, so one counter value raises a channel at most once, however many clocks the value is held.
- R8: While the watchdog is armed, a match on channel 3 raises `wdt_rst_o` at the same edge as the one that would set status bit 3, whatever interrupt enable bit 3 holds.
- R9: `wdt_rst_o` stays high for exactly PULSE_CYCLES clocks (default 4, never less than 4) and never rises while the watchdog is disarmed.
- R10: Writing a one to word 7, bit 0 arms the watchdog. Writing a zero there has no effect. Only reset disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable, one per timebase period |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| irq_o | output | 4 | Per-channel interrupt requests |
| wdt_rst_o | output | 1 | Registered watchdog reset request pulse |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit counter and a 4-clock reset pulse. The full width brings the all-ones wrap within a few clocks, because the counter can be loaded just below it. The 4-clock pulse is short enough to measure its length clock by clock, and channel 3 is the watchdog channel. Holding `tick_i` low between pulses exercises the once-per-value match rule, the clear racing a set at the same edge, and the arming sequence with no stray match.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_ARMED  = 2'd1,
        WD_FIRING = 2'd2
    } wd_state_e;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int unsigned CW       = 32,
    parameter int unsigned AW       = 3,
    parameter int unsigned CNT_WORD = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cnt_o
);
    logic          load;
    logic [CW-1:0] cnt_q;

    assign load = wr_i && (addr_i == AW'(CNT_WORD));

    // No reset on purpose: the count survives every reset.
    always_ff @(posedge clk_i) begin
        if (load)        cnt_q <= wdata_i;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$isunknown($past(cnt_q)) && $past(tick_i) && !$past(load))
            |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/frt_compare.sv
module frt_compare #(
    parameter int unsigned NCH      = 4,
    parameter int unsigned CW       = 32,
    parameter int unsigned AW       = 3,
    parameter int unsigned STS_WORD = 5,
    parameter int unsigned IEN_WORD = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tick_i,
    input  logic                    wr_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [CW-1:0]           wdata_i,
    input  logic [CW-1:0]           cnt_i,
    output logic [NCH-1:0][CW-1:0]  cmp_o,
    output logic [NCH-1:0]          sts_o,
    output logic [NCH-1:0]          ien_o,
    output logic [NCH-1:0]          hit_o
);
    logic [NCH-1:0] ien_q;
    logic           sts_wr;
    logic           ien_wr;

    assign sts_wr = wr_i && (addr_i == AW'(STS_WORD));
    assign ien_wr = wr_i && (addr_i == AW'(IEN_WORD));

    always_ff @(posedge clk_i) begin
        if (ien_wr) ien_q <= wdata_i[NCH-1:0];
    end
    assign ien_o = ien_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] cmp_q;
        logic          sts_q;
        logic          sts_d;
        logic          clr;

        always_ff @(posedge clk_i) begin
            if (wr_i && (addr_i == AW'(g))) cmp_q <= wdata_i;
        end

        assign hit_o[g] = tick_i && (cnt_i == cmp_q);
        assign clr      = sts_wr && wdata_i[g];

        always_comb begin
            sts_d = sts_q;
            if (clr)                  sts_d = 1'b0;
            if (hit_o[g] && ien_q[g]) sts_d = 1'b1;
        end

        always_ff @(posedge clk_i) begin
            sts_q <= sts_d;
        end

        assign cmp_o[g] = cmp_q;
        assign sts_o[g] = sts_q;

        // R4
        sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_i && (cnt_i == cmp_q) && ien_q[g]) |=> sts_q);

        // R6
        sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sts_wr && wdata_i[g] && !(hit_o[g] && ien_q[g])) |=> !sts_q);

        // R7
        sts_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!tick_i && !sts_q) |=> !sts_q);
    end
endmodule

// File: rtl/frt_wdog.sv
module frt_wdog
    import frt_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 4,
    parameter int unsigned AW           = 3,
    parameter int unsigned CW           = 32,
    parameter int unsigned WDE_WORD     = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          hit_i,
    output logic          en_o,
    output logic          rst_o
);
    localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);

    wd_state_e     state_q;
    wd_state_e     state_d;
    logic [PW-1:0] pulse_q;
    logic          rst_q;
    logic          arm;

    assign arm = wr_i && (addr_i == AW'(WDE_WORD)) && wdata_i[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WD_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:   if (arm) state_d = WD_ARMED;
            WD_ARMED:  if (hit_i) state_d = WD_FIRING;
            WD_FIRING: if (pulse_q == PW'(PULSE_CYCLES - 1)) state_d = WD_ARMED;
            default:   state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= '0;
            rst_q   <= 1'b0;
        end else begin
            pulse_q <= (state_q == WD_FIRING) ? pulse_q + 1'b1 : '0;
            rst_q   <= (state_d == WD_FIRING);
        end
    end

    assign en_o  = (state_q != WD_IDLE);
    assign rst_o = rst_q;

    // R9
    initial pulse_len_param_chk: assert (PULSE_CYCLES >= 4);

    // R8
    wd_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o && !rst_o && hit_i) |=> rst_o);

    // R9
    wd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |=> !rst_o);

    // R9
    wd_pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_o && (pulse_q < PW'(PULSE_CYCLES - 1))) |=> rst_o);

    // R10
    wd_arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> en_o);
endmodule

// File: rtl/frt_wdt_timer.sv
module frt_wdt_timer #(
    parameter int unsigned NCH          = 4,
    parameter int unsigned CW           = 32,
    parameter int unsigned PULSE_CYCLES = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      tick_i,
    input  logic                      bus_wr_i,
    input  logic [$clog2(NCH+4)-1:0]  bus_addr_i,
    input  logic [CW-1:0]             bus_wdata_i,
    output logic [CW-1:0]             bus_rdata_o,
    output logic [NCH-1:0]            irq_o,
    output logic                      wdt_rst_o
);
    localparam int unsigned AW       = $clog2(NCH + 4);
    localparam int unsigned CNT_WORD = NCH;
    localparam int unsigned STS_WORD = NCH + 1;
    localparam int unsigned IEN_WORD = NCH + 2;
    localparam int unsigned WDE_WORD = NCH + 3;
    localparam int unsigned WD_CH    = NCH - 1;

    logic [CW-1:0]           cnt;
    logic [NCH-1:0][CW-1:0]  cmp;
    logic [NCH-1:0]          sts;
    logic [NCH-1:0]          ien;
    logic [NCH-1:0]          hit;
    logic                    wd_en;

    frt_counter #(.CW(CW), .AW(AW), .CNT_WORD(CNT_WORD)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    frt_compare #(.NCH(NCH), .CW(CW), .AW(AW),
                  .STS_WORD(STS_WORD), .IEN_WORD(IEN_WORD)) u_cmp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .cnt_i   (cnt),
        .cmp_o   (cmp),
        .sts_o   (sts),
        .ien_o   (ien),
        .hit_o   (hit)
    );

    frt_wdog #(.PULSE_CYCLES(PULSE_CYCLES), .AW(AW), .CW(CW),
               .WDE_WORD(WDE_WORD)) u_wd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .hit_i   (hit[WD_CH]),
        .en_o    (wd_en),
        .rst_o   (wdt_rst_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr_i == AW'(i)) bus_rdata_o = cmp[i];
        end
        if (bus_addr_i == AW'(CNT_WORD)) bus_rdata_o = cnt;
        if (bus_addr_i == AW'(STS_WORD)) bus_rdata_o = {{(CW-NCH){1'b0}}, sts};
        if (bus_addr_i == AW'(IEN_WORD)) bus_rdata_o = {{(CW-NCH){1'b0}}, ien};
        if (bus_addr_i == AW'(WDE_WORD)) bus_rdata_o = {{(CW-1){1'b0}}, wd_en};
    end

    assign irq_o = sts;

    // R5
    irq_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit[0] && ien[0]) |=> irq_o[0]);
endmodule

// File: tb/frt_wdt_timer_tb_top.sv
module frt_wdt_timer_tb_top;
    localparam int unsigned W_CNT = 4;
    localparam int unsigned W_STS = 5;
    localparam int unsigned W_IEN = 6;
    localparam int unsigned W_WDE = 7;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [3:0]  irq_o;
    logic        wdt_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk_i = ~clk_i;

    frt_wdt_timer dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .wdt_rst_o   (wdt_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk_i);
        bus_wr_i = 1'b1; bus_addr_i = 3'(a); bus_wdata_i = d;
        @(negedge clk_i);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr_i = 3'(a);
        #1;
        d = bus_rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_i); tick_i = 1'b1;
        end
        @(negedge clk_i); tick_i = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(W_WDE, v);
        chk("R2 arm bit after reset", v, 32'd0);
        chk("R2 wdt_rst_o after reset", {31'd0, wdt_rst_o}, 32'd0);
    endtask

    task automatic t_counter();
        logic [31:0] v;
        tick_i = 1'b0;
        wr(W_CNT, 32'h1234_0000);
        rd(W_CNT, v);
        chk("R1 counter load", v, 32'h1234_0000);
        repeat (5) @(negedge clk_i);
        rd(W_CNT, v);
        chk("R1 hold without tick", v, 32'h1234_0000);
        ticks(7);
        rd(W_CNT, v);
        chk("R1 seven ticks", v, 32'h1234_0007);
        wr(W_CNT, 32'hFFFF_FFFE);
        ticks(3);
        rd(W_CNT, v);
        chk("R1 wrap", v, 32'h0000_0001);
    endtask

    task automatic t_cmp_rw();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) wr(i, 32'hA500_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < 4; i++) begin
            rd(i, v);
            chk("R3 compare readback", v, 32'hA500_0000 + 32'(i) * 32'h111);
        end
    endtask

    task automatic t_match();
        logic [31:0] v;
        tick_i = 1'b0;
        wr(0, 32'd103);
        wr(1, 32'd103);
        wr(2, 32'h7000_0000);
        wr(3, 32'h7000_0000);
        wr(W_IEN, 32'h1);
        wr(W_STS, 32'hF);
        wr(W_CNT, 32'd100);
        rd(W_STS, v);
        chk("R4 status clear before match", v, 32'h0);
        tick_i = 1'b1;
        repeat (3) @(negedge clk_i);
        rd(W_STS, v);
        chk("R4 no status while value not yet counted", v, 32'h0);
        @(negedge clk_i);
        rd(W_STS, v);
        chk("R4 status on enabled channel only", v, 32'h1);
        chk("R5 irq mirrors status", {28'd0, irq_o}, 32'h1);
        tick_i = 1'b0;
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(W_STS, 32'h0);
        rd(W_STS, v);
        chk("R6 write zero keeps bit", v, 32'h1);
        wr(W_STS, 32'h2);
        rd(W_STS, v);
        chk("R6 other bit position keeps bit", v, 32'h1);
        wr(W_STS, 32'h1);
        rd(W_STS, v);
        chk("R6 write one clears", v, 32'h0);
        chk("R5 irq low after clear", {28'd0, irq_o}, 32'h0);
        wr(0, 32'd200);
        wr(W_CNT, 32'd200);
        @(negedge clk_i);
        bus_wr_i = 1'b1; bus_addr_i = 3'(W_STS); bus_wdata_i = 32'h1; tick_i = 1'b1;
        @(negedge clk_i);
        bus_wr_i = 1'b0; tick_i = 1'b0;
        rd(W_STS, v);
        chk("R6 set wins over clear", v, 32'h1);
    endtask

    task automatic t_once();
        logic [31:0] v;
        tick_i = 1'b0;
        wr(0, 32'd300);
        wr(W_CNT, 32'd299);
        wr(W_STS, 32'hF);
        ticks(1);
        repeat (5) @(negedge clk_i);
        rd(W_STS, v);
        chk("R7 held value without tick raises nothing", v, 32'h0);
        ticks(1);
        rd(W_STS, v);
        chk("R7 match on tick", v, 32'h1);
        wr(W_STS, 32'h1);
        ticks(2);
        rd(W_STS, v);
        chk("R7 no repeat after value left", v, 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        int highs;
        logic first;
        tick_i = 1'b0;
        wr(W_IEN, 32'h0);
        wr(3, 32'd500);
        wr(W_CNT, 32'd500);
        wr(W_STS, 32'hF);
        wr(W_WDE, 32'h0);
        rd(W_WDE, v);
        chk("R10 zero write does not arm", v, 32'h0);
        wr(W_WDE, 32'h1);
        rd(W_WDE, v);
        chk("R10 arm", v, 32'h1);
        repeat (3) @(negedge clk_i);
        chk("R9 no pulse without tick", {31'd0, wdt_rst_o}, 32'h0);
        tick_i = 1'b1;
        @(negedge clk_i);
        tick_i = 1'b0;
        first = wdt_rst_o;
        highs = 0;
        for (int k = 0; k < 8; k++) begin
            if (wdt_rst_o) highs++;
            @(negedge clk_i);
        end
        chk("R8 reset request right after match", {31'd0, first}, 32'h1);
        chk("R9 pulse length", 32'(highs), 32'd4);
        rd(W_STS, v);
        chk("R8 trip independent of irq enable", v, 32'h0);
        wr(W_WDE, 32'h0);
        rd(W_WDE, v);
        chk("R10 zero write does not disarm", v, 32'h1);
    endtask

    task automatic t_reset_keep();
        logic [31:0] v;
        tick_i = 1'b0;
        wr(W_CNT, 32'hCAFE_0000);
        wr(2, 32'h0BAD_F00D);
        @(negedge clk_i); rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        rd(W_CNT, v);
        chk("R2 counter survives reset", v, 32'hCAFE_0000);
        rd(2, v);
        chk("R2 compare survives reset", v, 32'h0BAD_F00D);
        rd(W_WDE, v);
        chk("R2 reset disarms watchdog", v, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset_state();
        t_counter();
        t_cmp_rw();
        t_match();
        t_w1c();
        t_once();
        t_wdog();
        t_reset_keep();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule